// File: doc/BRIEF.md
# Sleep Sequencer with Periodic Supply-Monitor Buzz

This block takes a small microcontroller into and out of a powered-down sleep state. A firmware strobe sets the sleep flag. The block then raises a halt request to the CPU and waits for the CPU's acknowledge. It drops power only on the next falling edge of the CPU clock. Power-down turns off the flash, the main oscillator and the bandgap reference.

During sleep, all timing comes from ticks of a low-speed clock. In standby sleep, the supply monitor and the reference refresh are switched on for short windows at a programmable interval. A keep-monitor option holds the supply monitor on for the whole of sleep. The deep variant switches off the low-speed oscillator, the refresh logic and the supply monitor, and enables a separate low-power voltage monitor instead.

A wake event or an accepted brown-out brings the block back to run. The main oscillator and the other gated blocks come back on, and a fixed number of low-speed ticks is allowed for settling. Then the halt request and the sleep flag are released. An accepted brown-out also raises a one-cycle reset request.

All logic runs on the fast system clock `clk`. The CPU clock and the low-speed clock reach the block as a sampled level (`cpu_clk_in`) and as a one-cycle tick strobe (`slow_tick`).

Top module: `slp_seq_top`

## Requirements
- R1: After reset, the block is in run. `bus_req`, `sleep_bit`, `pwr_down`, `refresh_en`, `lpvm_en` and `rst_req` are low. `flash_en`, `osc_en`, `ref_en`, `lso_en` and `svm_en` are high.
- R2: A `sleep_wr` strobe in run, with `wake_evt` low, raises `sleep_bit` and `bus_req` on the next clock edge. `period_sel`, `keep_monitor` and `deep_sel` are captured at that edge, and later changes to them have no effect until the next sleep.
- R3: `pwr_down` rises only after `bus_ack` has been seen and `cpu_clk_in` has then gone from high to low. It rises on the clock edge that samples `cpu_clk_in` low after a cycle in which it was high. While `cpu_clk_in` stays high, `pwr_down` stays low.
- R4: While `pwr_down` is high, `flash_en`, `osc_en` and `ref_en` are low. At all other times they are high.
- R5: In standby sleep, let P = 1, 8, 64 or 512 for a `period_sel` code of 0, 1, 2 or 3. After the k-th low-speed tick of sleep, `svm_en` and `refresh_en` are high exactly when k mod (P+2) is P or P+1. Both are low before the first tick.
- R6: With `keep_monitor` captured high in standby sleep, `svm_en` stays high for the whole of sleep. `refresh_en` still follows the R5 pattern.
- R7: In deep sleep (`deep_sel` captured high), `lso_en`, `svm_en` and `refresh_en` stay low and `lpvm_en` stays high for the whole of sleep.
- R8: When `wake_evt` is high during sleep, `pwr_down` falls on the next edge and `osc_en` rises with it. `bus_req` and `sleep_bit` stay high through 15 low-speed ticks. Both fall on the 16th tick.
- R9: When `brownout` is high in sleep while `svm_en` is high, `rst_req` is high for exactly one cycle, and the block leaves sleep and settles as in R8. When `svm_en` is low, `brownout` is ignored and `pwr_down` stays high.
- R10: If `wake_evt` and an accepted `brownout` arrive in the same cycle, the block still raises `rst_req`.
- R11: A `sleep_wr` strobe while `wake_evt` is high is ignored. `sleep_bit`, `bus_req` and `pwr_down` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_wr | input | 1 | Firmware strobe that sets the sleep flag |
| period_sel | input | 2 | Buzz interval code (0..3 for 1, 8, 64 or 512 ticks) |
| keep_monitor | input | 1 | Hold the supply monitor on through sleep |
| deep_sel | input | 1 | Select deep sleep instead of standby |
| cpu_clk_in | input | 1 | Sampled level of the CPU clock |
| bus_ack | input | 1 | CPU acknowledge of the halt request |
| slow_tick | input | 1 | One-cycle strobe per low-speed clock period |
| wake_evt | input | 1 | Wake event level |
| brownout | input | 1 | Brown-out flag from the supply monitor |
| bus_req | output | 1 | Halt request to the CPU |
| sleep_bit | output | 1 | Sleep flag as seen by firmware |
| pwr_down | output | 1 | System-wide power-down |
| flash_en | output | 1 | Flash enable |
| osc_en | output | 1 | Main oscillator enable |
| ref_en | output | 1 | Bandgap reference enable |
| lso_en | output | 1 | Low-speed oscillator enable |
| refresh_en | output | 1 | Reference refresh enable |
| svm_en | output | 1 | Supply monitor enable |
| lpvm_en | output | 1 | Low-power voltage monitor enable (deep sleep) |
| rst_req | output | 1 | One-cycle reset request after an accepted brown-out |

## Verification
A wake event and a brown-out can land in the same cycle during a buzz window. The block must then resolve to the reset-request path rather than a plain wake. The bench provokes this by ticking into the first buzz window and raising both inputs on the same falling clock edge. It then expects `rst_req` high and `pwr_down` low one edge later, and `rst_req` low again on the edge after that. The table walk covers the related boundary: brown-out arriving in the gap of a buzz period and in deep sleep, where it must be ignored.

// File: rtl/slp_seq_pkg.sv
// Shared types for the sleep sequencer.
// Assumes: all users import the package; the period code width is fixed here.
package slp_seq_pkg;

    localparam int unsigned PERIOD_SEL_W = 2;

    // Sequencer phases from run through halt, sleep and settle.
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_REQ    = 3'd1,
        ST_HALT   = 3'd2,
        ST_SLEEP  = 3'd3,
        ST_SETTLE = 3'd4
    } seq_state_t;

    // Sleep options captured at the accepted firmware write.
    typedef struct packed {
        logic [PERIOD_SEL_W-1:0] period_sel;
        logic                    keep_monitor;
        logic                    deep;
    } sleep_cfg_t;

endpackage

// File: rtl/slp_edge_watch.sv
// Detects a high-to-low transition of a level sampled on clk.
// Assumes: the level is already synchronous to clk.
module slp_edge_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/slp_buzz_timer.sv
// Counts low-speed ticks during sleep: a gap of 8^sel ticks, then a window
// of BUZZ_TICKS ticks with buzz high, repeating.
// Assumes: run is low outside sleep, which restarts the pattern in the gap.
module slp_buzz_timer #(
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned STEP_LOG2  = 3,
    parameter int unsigned BUZZ_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             buzz
);
    localparam int unsigned NSEL    = 1 << SEL_W;
    localparam int unsigned MAX_GAP = 1 << (STEP_LOG2 * (NSEL - 1));
    localparam int unsigned CNT_W   = $clog2(MAX_GAP + BUZZ_TICKS);
    localparam logic [CNT_W-1:0] BUZZ_LAST = CNT_W'(BUZZ_TICKS - 1);

    logic [CNT_W-1:0] gap_last [NSEL];
    logic [CNT_W-1:0] cnt_q;
    logic             buzz_q;

    // One gap limit per period code.
    for (genvar i = 0; i < NSEL; i++) begin : g_gap
        assign gap_last[i] = CNT_W'((1 << (STEP_LOG2 * i)) - 1);
    end

    // Advance the gap/buzz counter on each low-speed tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            buzz_q <= 1'b0;
        end else if (tick) begin
            if (!buzz_q) begin
                if (cnt_q == gap_last[sel]) begin
                    cnt_q  <= '0;
                    buzz_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == BUZZ_LAST) begin
                    cnt_q  <= '0;
                    buzz_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign buzz = buzz_q;
endmodule

// File: rtl/slp_settle_timer.sv
// Counts TICKS low-speed ticks after wake-up. done pulses on the last one.
// Assumes: run stays high until done has been seen.
module slp_settle_timer #(
    parameter int unsigned TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks while settling; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end

    assign done = run & tick & (cnt_q == LAST);
endmodule

// File: rtl/slp_seq_top.sv
// Sleep sequencer top.
// Orders the halt handshake before power-down and duty-cycles the monitors
// while asleep. Wake events and brown-outs bring the block back through a
// settle interval.
// Assumes: cpu_clk_in and slow_tick are synchronous to clk, and slow_tick is
// one cycle wide.
module slp_seq_top import slp_seq_pkg::*; #(
    parameter int unsigned STEP_LOG2    = 3,
    parameter int unsigned BUZZ_TICKS   = 2,
    parameter int unsigned SETTLE_TICKS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_wr,
    input  logic [PERIOD_SEL_W-1:0] period_sel,
    input  logic                    keep_monitor,
    input  logic                    deep_sel,
    input  logic                    cpu_clk_in,
    input  logic                    bus_ack,
    input  logic                    slow_tick,
    input  logic                    wake_evt,
    input  logic                    brownout,
    output logic                    bus_req,
    output logic                    sleep_bit,
    output logic                    pwr_down,
    output logic                    flash_en,
    output logic                    osc_en,
    output logic                    ref_en,
    output logic                    lso_en,
    output logic                    refresh_en,
    output logic                    svm_en,
    output logic                    lpvm_en,
    output logic                    rst_req
);
    seq_state_t state_q, state_d;
    sleep_cfg_t cfg_q;
    logic       sleep_q;
    logic       rst_q;
    logic       cpu_fall;
    logic       buzz;
    logic       settle_done;
    logic       in_sleep;
    logic       accept_wr;
    logic       bo_take;
    logic       wake_take;

    slp_edge_watch u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (cpu_clk_in),
        .fall  (cpu_fall)
    );

    slp_buzz_timer #(
        .SEL_W      (PERIOD_SEL_W),
        .STEP_LOG2  (STEP_LOG2),
        .BUZZ_TICKS (BUZZ_TICKS)
    ) u_buzz (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_sleep),
        .tick  (slow_tick),
        .sel   (cfg_q.period_sel),
        .buzz  (buzz)
    );

    slp_settle_timer #(
        .TICKS (SETTLE_TICKS)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SETTLE),
        .tick  (slow_tick),
        .done  (settle_done)
    );

    // Decode the events that move the sequencer.
    always_comb begin
        in_sleep  = (state_q == ST_SLEEP);
        accept_wr = (state_q == ST_RUN) && sleep_wr && !wake_evt;
        bo_take   = in_sleep && brownout && svm_en;
        wake_take = in_sleep && wake_evt;
    end

    // Next-state selection for the run/halt/sleep/settle cycle.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:    if (accept_wr)            state_d = ST_REQ;
            ST_REQ:    if (bus_ack)              state_d = ST_HALT;
            ST_HALT:   if (cpu_fall)             state_d = ST_SLEEP;
            ST_SLEEP:  if (bo_take || wake_take) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done)          state_d = ST_RUN;
            default:                             state_d = ST_RUN;
        endcase
    end

    // State, captured options, sleep flag and reset-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cfg_q   <= '0;
            sleep_q <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rst_q   <= bo_take;
            if (accept_wr) begin
                cfg_q   <= '{period_sel: period_sel,
                             keep_monitor: keep_monitor,
                             deep: deep_sel};
                sleep_q <= 1'b1;
            end else if (settle_done) begin
                sleep_q <= 1'b0;
            end
        end
    end

    // Output enables derived from the phase and the captured options.
    always_comb begin
        bus_req    = (state_q != ST_RUN);
        sleep_bit  = sleep_q;
        pwr_down   = in_sleep;
        flash_en   = !in_sleep;
        osc_en     = !in_sleep;
        ref_en     = !in_sleep;
        lso_en     = !(in_sleep && cfg_q.deep);
        lpvm_en    = in_sleep && cfg_q.deep;
        svm_en     = !in_sleep || (!cfg_q.deep && (cfg_q.keep_monitor || buzz));
        refresh_en = in_sleep && !cfg_q.deep && buzz;
        rst_req    = rst_q;
    end
endmodule

// File: rtl/slp_seq_chk.sv
// Property checker for the sleep sequencer, bound to every slp_seq_top.
// Assumes: port-level view only.
module slp_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_wr,
    input logic wake_evt,
    input logic brownout,
    input logic cpu_clk_in,
    input logic bus_req,
    input logic sleep_bit,
    input logic pwr_down,
    input logic svm_en,
    input logic refresh_en,
    input logic lso_en,
    input logic lpvm_en,
    input logic rst_req
);
    p_write_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_wr && !wake_evt && !bus_req) |=> (bus_req && sleep_bit));

    p_flag_tracks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_bit == bus_req);

    p_pd_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> ($past(bus_req) && !$past(cpu_clk_in) && $past(cpu_clk_in, 2)));

    p_refresh_asleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_en |-> pwr_down);

    p_deep_monitors_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lpvm_en |-> (pwr_down && !svm_en && !refresh_en && !lso_en));

    p_settle_holds_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> bus_req);

    p_rst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_rst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(brownout) && $past(svm_en) && $past(pwr_down)));

    p_ignored_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_wr && wake_evt && !bus_req) |=> !bus_req);
endmodule

bind slp_seq_top slp_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_wr   (sleep_wr),
    .wake_evt   (wake_evt),
    .brownout   (brownout),
    .cpu_clk_in (cpu_clk_in),
    .bus_req    (bus_req),
    .sleep_bit  (sleep_bit),
    .pwr_down   (pwr_down),
    .svm_en     (svm_en),
    .refresh_en (refresh_en),
    .lso_en     (lso_en),
    .lpvm_en    (lpvm_en),
    .rst_req    (rst_req)
);

// File: tb/tb_slp_seq_top.sv
`timescale 1ns/1ps
module tb_slp_seq_top;
    logic       clk = 1'b0;
    logic       rst_n, sleep_wr, keep_monitor, deep_sel, cpu_clk_in, bus_ack;
    logic       slow_tick, wake_evt, brownout;
    logic [1:0] period_sel;
    logic       bus_req, sleep_bit, pwr_down, flash_en, osc_en, ref_en;
    logic       lso_en, refresh_en, svm_en, lpvm_en, rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    slp_seq_top dut (
        .clk(clk), .rst_n(rst_n), .sleep_wr(sleep_wr), .period_sel(period_sel),
        .keep_monitor(keep_monitor), .deep_sel(deep_sel), .cpu_clk_in(cpu_clk_in),
        .bus_ack(bus_ack), .slow_tick(slow_tick), .wake_evt(wake_evt),
        .brownout(brownout), .bus_req(bus_req), .sleep_bit(sleep_bit),
        .pwr_down(pwr_down), .flash_en(flash_en), .osc_en(osc_en), .ref_en(ref_en),
        .lso_en(lso_en), .refresh_en(refresh_en), .svm_en(svm_en),
        .lpvm_en(lpvm_en), .rst_req(rst_req)
    );

    // Vector: [15:14] period code, [13] keep, [12] deep, [11] use brown-out, [7:0] ticks
    localparam int NVEC = 8;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0007, 16'h4815, 16'h4809, 16'h2805,
        16'h8042, 16'hC00C, 16'h580A, 16'hB804
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) slow_tick = 1'b1;
        @(negedge clk) slow_tick = 1'b0;
    endtask

    function automatic bit buzz_at(input int k, input logic [1:0] sel);
        int p;
        p = 1 << (3 * sel);
        return (k > 0) && ((k % (p + 2)) >= p);
    endfunction

    task automatic enter_sleep(input logic [1:0] sel, input logic keep, input logic deep);
        @(negedge clk);
        period_sel = sel; keep_monitor = keep; deep_sel = deep; sleep_wr = 1'b1;
        @(negedge clk);
        sleep_wr = 1'b0;
        check("R2 request raised", {bus_req, sleep_bit}, 2'b11);
        cpu_clk_in = 1'b1; bus_ack = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R3 no pd while cpu clock high", pwr_down, 1'b0);
        cpu_clk_in = 1'b0;
        @(negedge clk);
        check("R3 pd after falling edge", pwr_down, 1'b1);
        check("R4 gated enables off", {flash_en, osc_en, ref_en}, 3'b000);
    endtask

    task automatic settle_back();
        for (int i = 0; i < 15; i++) tick();
        check("R8 request held in settle", {bus_req, sleep_bit, pwr_down}, 3'b110);
        tick();
        check("R8 released after 16 ticks", {bus_req, sleep_bit, pwr_down}, 3'b000);
        check("R4 enables on in run", {flash_en, osc_en, ref_en}, 3'b111);
        bus_ack = 1'b0;
    endtask

    task automatic wake_normal();
        @(negedge clk) wake_evt = 1'b1;
        @(negedge clk) wake_evt = 1'b0;
        check("R8 wake leaves sleep", {pwr_down, osc_en, rst_req}, 3'b010);
    endtask

    initial begin
        rst_n = 1'b0; sleep_wr = 1'b0; period_sel = 2'd0; keep_monitor = 1'b0;
        deep_sel = 1'b0; cpu_clk_in = 1'b0; bus_ack = 1'b0; slow_tick = 1'b0;
        wake_evt = 1'b0; brownout = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset outputs",
              {bus_req, sleep_bit, pwr_down, flash_en, osc_en, ref_en,
               lso_en, refresh_en, svm_en, lpvm_en, rst_req},
              11'b000_111_1_0_1_0_0);

        // Table walk over sleep configurations
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] sel;
            logic keep, deep, use_bo;
            int n;
            bit b, s;
            string tag;
            sel = VEC[v][15:14]; keep = VEC[v][13]; deep = VEC[v][12];
            use_bo = VEC[v][11]; n = int'(VEC[v][7:0]);
            tag = deep ? "R7 deep monitors" : (keep ? "R6 kept monitor" : "R5 buzz window");
            enter_sleep(sel, keep, deep);
            s = 1'b0;
            for (int k = 1; k <= n; k++) begin
                tick();
                b = buzz_at(k, sel) && !deep;
                s = deep ? 1'b0 : (keep | b);
                check(tag, {svm_en, refresh_en, lso_en, lpvm_en}, {s, b, !deep, deep});
            end
            if (use_bo) begin
                @(negedge clk) brownout = 1'b1;
                @(negedge clk) brownout = 1'b0;
                if (s) begin
                    check("R9 accepted brown-out", {rst_req, pwr_down}, 2'b10);
                    @(negedge clk);
                    check("R9 reset request one cycle", rst_req, 1'b0);
                end else begin
                    check("R9 ignored brown-out", {rst_req, pwr_down}, 2'b01);
                    wake_normal();
                end
            end else begin
                wake_normal();
            end
            settle_back();
        end

        // R11: write with a wake pending is dropped
        @(negedge clk) begin wake_evt = 1'b1; sleep_wr = 1'b1; end
        @(negedge clk) begin wake_evt = 1'b0; sleep_wr = 1'b0; end
        repeat (4) @(negedge clk);
        check("R11 write ignored", {bus_req, sleep_bit, pwr_down}, 3'b000);

        // R2: options captured at write; later input changes have no effect
        enter_sleep(2'd0, 1'b0, 1'b0);
        period_sel = 2'd3; keep_monitor = 1'b1; deep_sel = 1'b1;
        tick();
        check("R2 captured period", {svm_en, refresh_en, lso_en, lpvm_en}, 4'b1110);
        tick(); tick();
        check("R2 captured keep/deep", {svm_en, refresh_en, lso_en, lpvm_en}, 4'b0010);
        wake_normal();
        settle_back();

        // R10: wake and brown-out in the same cycle during a buzz window
        enter_sleep(2'd0, 1'b0, 1'b0);
        tick();
        check("R10 in buzz before clash", svm_en, 1'b1);
        @(negedge clk) begin wake_evt = 1'b1; brownout = 1'b1; end
        @(negedge clk) begin wake_evt = 1'b0; brownout = 1'b0; end
        check("R10 reset wins over wake", {rst_req, pwr_down}, 2'b10);
        @(negedge clk);
        check("R10 reset request drops", rst_req, 1'b0);
        settle_back();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule